// File: doc/BRIEF.md
# Selectable Dual State-Sequence Generator

This block is a four-stage shift register with fixed feedback into its first stage. It steps through a cycle of fourteen non-zero 4-bit states. It starts from an all-zero entry state and never returns to it. Every rising clock edge moves each stage one place toward the most significant bit, and a fixed lookup supplies the new first-stage bit.

A single select input sets the output polarity. When select is low, the output shows the stored state as it is. When select is high, the output shows its bitwise complement. One register cycle therefore gives two different output sequences: 0,1,2,5,10,4,9,3,6,13,11,7,14,12,8 followed by a repeat from 1, or the complement sequence 15,14,13,10,5,11,6,12,9,2,4,8,1,3,7. The select input acts through combinational logic only. It never reaches the stored state, so switching sequences keeps the current position in the cycle.

Top module: `dual_seq_gen`

## Requirements
- R1: When `rst_n` is low at a rising edge, the stored state becomes 0. The output is then 0 with `sel_cpl`=0 and 15 with `sel_cpl`=1.
- R2: With `sel_cpl`=0, the edges after reset release produce the outputs 1,2,5,10,4,9,3,6,13,11,7,14,12,8 in that order. The run then repeats from 1 with a period of 14 edges.
- R3: With `sel_cpl`=1, the output at each position is the 4-bit complement of the R2 value. From reset this gives 15, then 14,13,10,5,11,6,12,9,2,4,8,1,3,7, repeating.
- R4: The stored state changes only on a rising clock edge. While `sel_cpl` is stable, the output holds its value between edges.
- R5: A change on `sel_cpl` flips all four output bits at once, without waiting for a clock edge.
- R6: Toggling `sel_cpl` between edges leaves the sequence position unchanged. The next edge gives the successor of the state held before the toggle.
- R7: After reset release, the stored state never returns to 0 and never becomes 15.
- R8: Bit 0 of `seq_out` is the first stage. On each edge, stored bits [3:1] take the previous bits [2:0], and bit 0 takes the feedback bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state advances on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset to the entry state 0 |
| sel_cpl | input | 1 | Sequence select: 0 gives the true state, 1 gives its complement |
| seq_out | output | 4 | Current state value, bit 0 = first stage |

## Verification
The stored state is due one edge after the clock sample that moves it, whether that sample is a reset or an advance. The bench therefore updates its model at each rising edge and compares the output 1 ns later. Select changes take effect with no clock at all. The bench changes `sel_cpl` in the middle of a cycle and compares after a 1 ns settle, with no edge in between. The position after a toggle is then confirmed at the next edge. Each stability check happens before the next edge, so the result due from one stimulus is never mixed with the result of the next.

// File: rtl/dseq_pkg.sv
// Shared constants and types for the dual state-sequence generator.
// Assumes a fixed four-stage register; the cycle lookup is defined for it.
package dseq_pkg;
    localparam int STAGES = 4;
    typedef logic [STAGES-1:0] stage_t;
    localparam stage_t ENTRY_STATE   = '0;
    localparam stage_t RECOVER_STATE = stage_t'(1);
endpackage

// File: rtl/seq_next_lut.sv
// Next-state lookup: maps each state of the 14-state cycle to its successor.
// The entry state 0 leads into the cycle. The unused value 15 is sent back into the cycle.
// Assumes STAGES == 4 (the table is written for 16 codes).
module seq_next_lut
    import dseq_pkg::*;
(
    input  stage_t cur,
    output stage_t nxt
);
    // Purpose: table lookup of the successor state.
    always_comb begin
        case (cur)
            4'd0:    nxt = 4'd1;
            4'd1:    nxt = 4'd2;
            4'd2:    nxt = 4'd5;
            4'd5:    nxt = 4'd10;
            4'd10:   nxt = 4'd4;
            4'd4:    nxt = 4'd9;
            4'd9:    nxt = 4'd3;
            4'd3:    nxt = 4'd6;
            4'd6:    nxt = 4'd13;
            4'd13:   nxt = 4'd11;
            4'd11:   nxt = 4'd7;
            4'd7:    nxt = 4'd14;
            4'd14:   nxt = 4'd12;
            4'd12:   nxt = 4'd8;
            4'd8:    nxt = 4'd1;
            default: nxt = RECOVER_STATE;
        endcase
    end

    // Purpose: a lookup entry never points a state to itself.
    always_comb begin
        if (!$isunknown(cur)) begin
            AST_LUT_NO_FIXED_POINT: assert (nxt != cur); // R2
        end
    end
endmodule

// File: rtl/seq_state_reg.sv
// State register: stores the four stages, loads the entry state on a synchronous
// active-low reset, and otherwise takes the lookup result on each rising edge.
// Assumes the successor in d is a one-place shift of q with a new bit 0.
module seq_state_reg
    import dseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  stage_t d,
    output stage_t q
);
    // Purpose: clocked storage of the stage values.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= ENTRY_STATE;
        else        q <= d;
    end

    // Purpose: checks on reset, the shift step and the states that are never reached.
    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (q == ENTRY_STATE)); // R1
    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (q[STAGES-1:1] == $past(q[STAGES-2:0]))); // R8
    AST_ENTRY_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (q != ENTRY_STATE) |=> (q != ENTRY_STATE)); // R7
    AST_NO_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (q != '1)); // R7
endmodule

// File: rtl/seq_polarity.sv
// Output polarity stage: passes the stored state through unchanged, or inverts it.
// Purely combinational, so a change on cpl shows at the output at once.
module seq_polarity
    import dseq_pkg::*;
(
    input  stage_t st,
    input  logic   cpl,
    output stage_t y
);
    // Purpose: invert every stage when cpl is high.
    assign y = st ^ {STAGES{cpl}};
endmodule

// File: rtl/dual_seq_gen.sv
// Top level: shift-register cycle with lookup feedback, and an output polarity
// selected without a clock. Assumes rst_n is held low for at least one edge at start-up.
module dual_seq_gen
    import dseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_cpl,
    output logic [3:0] seq_out
);
    stage_t state_q;
    stage_t state_d;

    // Purpose: compute the successor of the current state.
    seq_next_lut u_lut (
        .cur (state_q),
        .nxt (state_d)
    );

    // Purpose: hold the state between edges.
    seq_state_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (state_d),
        .q     (state_q)
    );

    // Purpose: apply the selected polarity to the output.
    seq_polarity u_pol (
        .st  (state_q),
        .cpl (sel_cpl),
        .y   (seq_out)
    );

    // Purpose: the select input never reaches the stored state.
    AST_SEL_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(sel_cpl) && $past(rst_n) |-> (state_q[STAGES-1:1] == $past(state_q[STAGES-2:0]))); // R6
endmodule

// File: tb/tb_dual_seq_gen.sv
module tb_dual_seq_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_cpl = 1'b0;
    logic [3:0] seq_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // model state
    bit   m_entry = 1'b1;
    int   m_pos   = 0;
    logic [3:0] prev_raw = 4'd0;
    bit   prev_ok = 1'b0;

    dual_seq_gen dut (.clk(clk), .rst_n(rst_n), .sel_cpl(sel_cpl), .seq_out(seq_out));

    always #5 clk = ~clk;

    function automatic logic [3:0] cycle_val(input int i);
        case (i)
            0: return 4'd1;   1: return 4'd2;   2: return 4'd5;   3: return 4'd10;
            4: return 4'd4;   5: return 4'd9;   6: return 4'd3;   7: return 4'd6;
            8: return 4'd13;  9: return 4'd11;  10: return 4'd7;  11: return 4'd14;
            12: return 4'd12; default: return 4'd8;
        endcase
    endfunction

    function automatic logic [3:0] model_raw();
        return m_entry ? 4'd0 : cycle_val(m_pos);
    endfunction

    function automatic logic [3:0] model_out(input logic s);
        return model_raw() ^ {4{s}};
    endfunction

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string req);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // one rising edge: update model, then sample 1 ns later
    task automatic tick(input string req);
        bit was_reset;
        @(posedge clk);
        was_reset = !rst_n;
        if (was_reset) m_entry = 1'b1;
        else if (m_entry) begin m_entry = 1'b0; m_pos = 0; end
        else m_pos = (m_pos + 1) % 14;
        #1;
        check(seq_out, model_out(sel_cpl), req);
        if (!was_reset && prev_ok)
            check((seq_out ^ {4{sel_cpl}}) & 4'b1110, {prev_raw[2:0], 1'b0}, "R8");
        prev_raw = seq_out ^ {4{sel_cpl}};
        prev_ok  = !was_reset || 1'b1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got 0 expected 1 (run completed)");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state under both polarities
        tick("R1"); tick("R1");
        #3 sel_cpl = 1'b1; #1 check(seq_out, 4'd15, "R1");
        sel_cpl = 1'b0; #1 check(seq_out, 4'd0, "R1");
        rst_n = 1'b1;
        // R2: two full periods, true polarity
        for (int i = 0; i < 28; i++) begin
            tick("R2");
            check({3'd0, (seq_out == 4'd0) || (seq_out == 4'd15)}, 4'd0, "R7");
            #3 check(seq_out, model_out(sel_cpl), "R4");
        end
        // R3: reset again, then two periods complemented
        #2 rst_n = 1'b0; sel_cpl = 1'b1;
        tick("R1");
        #2 rst_n = 1'b1;
        for (int i = 0; i < 29; i++) begin
            tick("R3");
            #3 check(seq_out, model_out(sel_cpl), "R4");
        end
        // R5 / R6: toggles between edges keep the position
        for (int i = 0; i < 20; i++) begin
            #2 sel_cpl = ~sel_cpl;
            #1 check(seq_out, model_out(sel_cpl), "R5");
            if (i % 2 == 0) begin
                #1 sel_cpl = ~sel_cpl;
                #1 check(seq_out, model_out(sel_cpl), "R5");
            end
            tick("R6");
        end
        // random phase
        for (int i = 0; i < 400; i++) begin
            #2;
            rst_n   = ($urandom_range(0, 31) != 0);
            sel_cpl = $urandom_range(0, 1);
            if ($urandom_range(0, 3) == 0) begin
                #1 sel_cpl = ~sel_cpl;
                #1 check(seq_out, model_out(sel_cpl), "R5");
            end
            tick(sel_cpl ? "R3" : "R2");
            if (!m_entry)
                check({3'd0, (model_raw() == seq_out ^ {4{sel_cpl}}) && (seq_out ^ {4{sel_cpl}}) != 4'd0}, 4'd1, "R7");
        end
        // directed: reset in mid-cycle, then the first step out of entry
        #2 rst_n = 1'b0; sel_cpl = 1'b0;
        tick("R1");
        #2 rst_n = 1'b1;
        tick("R2");
        check(seq_out, 4'd1, "R2");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule